// File: doc/BRIEF.md
# Video Memory Command Port

This block sits between a 16-bit CPU bus and a video processor's local memories and its configuration registers. The CPU writes control words to a command port. Each control word is either a one-word register update or one half of a two-word access command. An access command selects a target memory (pattern memory, colour memory or vertical-scroll memory), a direction and a 16-bit byte address.

After a write command, each data-port write is queued in a small FIFO together with its target and address, and the address then moves on by a programmable step. An external access-slot strobe drains the FIFO head into memory, one entry per strobe. After a read command, the block fetches the addressed word into a read buffer ahead of time, so that a data-port read returns the buffer and starts the next fetch.

A status word gives the FIFO empty and full flags, a fixed signature, and a byte of display-side status bits that come in from outside. When a data-port access cannot complete, a wait output holds the CPU.

Top module: `vpc_port`

## Requirements
- R1: After reset the FIFO is empty, `status_o` reads 16'h3600 when `ext_stat_i` is zero, `wait_o` is low and `rd_data_o` is zero.
- R2: A control word with bits 15:14 equal to 2'b10 is a register update. Bits 12:8 give the register index and bits 7:0 give the value. An index of 24 or more is dropped. `reg_val_o` shows the register that `reg_sel_i` selects, and reads 0 for an index outside the register file.
- R3: Any other control word, received when no command is pending, is a first command word: bits 15:14 are code bits 1:0 and bits 13:0 are address bits 13:0. The next control word completes the command: bits 7:4 are code bits 5:2 and bits 1:0 are address bits 15:14. Pattern memory is indexed by address bits 10:1, and the other two memories by address bits 6:1.
- R4: The 6-bit code selects the target: 000000 pattern read, 000001 pattern write, 001000 colour read, 000011 colour write, 000100 scroll read, 000101 scroll write. Any other code selects no target. A write under such a code changes no memory, and a read under it returns 0.
- R5: Every accepted data-port write and every fetch adds the 8-bit value of register 15 to the address, modulo 2^16.
- R6: The FIFO holds 4 entries. While it is full, a data-port write raises `wait_o` and is held. The write is accepted in the cycle after a slot strobe frees an entry.
- R7: `status_o` holds 6'b001101 in bits 15:10, FIFO empty in bit 9, FIFO full in bit 8, and `ext_stat_i` in bits 7:0. Bits 9 and 8 are both 0 while the FIFO is partly filled.
- R8: Entries leave the FIFO only on a `slot_i` cycle, one per cycle, in the order they were written.
- R9: Colour memory keeps 9 bits, taken from data bits 11:9, 7:5 and 3:1. A colour read returns those bits in the same positions, with every other bit 0.
- R10: A status read or an accepted data-port access drops a pending first command word. The next control word is then decoded as a fresh word.
- R11: A read command fetches the addressed word into the read buffer once the FIFO is empty, and then advances the address. A data-port read returns the buffer and starts the next fetch. While a fetch is outstanding, a data-port access raises `wait_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control-port write strobe |
| data_wr_i | input | 1 | Data-port write request, held while `wait_o` is high |
| data_rd_i | input | 1 | Data-port read request, held while `wait_o` is high |
| stat_rd_i | input | 1 | Status read strobe |
| bus_data_i | input | 16 | CPU write data for the control and data ports |
| slot_i | input | 1 | Memory access slot, drains one FIFO entry |
| ext_stat_i | input | 8 | Display-side status bits shown in the low status byte |
| reg_sel_i | input | 5 | Register index for `reg_val_o` |
| wait_o | output | 1 | CPU hold for a data-port access |
| rd_data_o | output | 16 | Read buffer returned by a data-port read |
| status_o | output | 16 | Status word |
| reg_val_o | output | 8 | Value of the selected register |

## Verification
The assertions assume that the CPU keeps a data-port request steady while `wait_o` is high. They also assume that it never raises a control write in the same cycle as an accepted data-port write, and never raises a data read and a data write together. The stimulus keeps to these rules. Every bus task drives a single strobe, starts one time unit after a rising edge, and holds its request until `wait_o` is low at a falling edge. The slot strobe is only pulsed from separate tasks or from a parallel branch that deliberately frees a full FIFO or releases an outstanding fetch.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [1:0] {TGT_NONE, TGT_VRAM, TGT_CRAM, TGT_VSRAM} tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic rd;
  } acc_t;

  typedef struct packed {
    tgt_e        tgt;
    logic [15:0] addr;
    logic [15:0] data;
  } wr_ent_t;

  // code bit 0 set means write direction
  function automatic acc_t decode_acc(input logic [5:0] c);
    acc_t a;
    a.rd  = ~c[0];
    a.tgt = TGT_NONE;
    case (c)
      6'b000000, 6'b000001: a.tgt = TGT_VRAM;
      6'b001000, 6'b000011: a.tgt = TGT_CRAM;
      6'b000100, 6'b000101: a.tgt = TGT_VSRAM;
      default:              a.tgt = TGT_NONE;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/vpc_cmd.sv
module vpc_cmd
  import vpc_pkg::*;
#(
  parameter int NUM_REGS = 24,
  parameter int STEP_REG = 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_wr_i,
  input  logic [15:0] ctrl_data_i,
  input  logic        stat_rd_i,
  input  logic        wr_acc_i,
  input  logic        rd_acc_i,
  input  logic        fetch_go_i,
  input  logic [4:0]  reg_sel_i,
  output logic [7:0]  reg_val_o,
  output logic [7:0]  step_o,
  output logic [15:0] addr_o,
  output acc_t        acc_o,
  output logic        pend_o,
  output logic        fetch_pend_o
);
  logic [7:0]  regs_q [NUM_REGS];
  logic [5:0]  code_q;
  logic [15:0] addr_q;
  logic        pend_q, fetch_pend_q;
  logic [4:0]  ridx;
  acc_t        acc_new;

  assign ridx    = ctrl_data_i[12:8];
  assign acc_new = decode_acc({ctrl_data_i[7:4], code_q[1:0]});
  assign step_o  = regs_q[STEP_REG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
      code_q       <= '0;
      addr_q       <= '0;
      pend_q       <= 1'b0;
      fetch_pend_q <= 1'b0;
    end else begin
      if (wr_acc_i || fetch_go_i) addr_q <= addr_q + {8'h00, regs_q[STEP_REG]};
      if (wr_acc_i || rd_acc_i || stat_rd_i) pend_q <= 1'b0;
      if (fetch_go_i) fetch_pend_q <= 1'b0;
      if (rd_acc_i)   fetch_pend_q <= 1'b1;
      if (ctrl_wr_i) begin
        if (pend_q) begin
          code_q[5:2]   <= ctrl_data_i[7:4];
          addr_q[15:14] <= ctrl_data_i[1:0];
          pend_q        <= 1'b0;
          if (acc_new.rd) fetch_pend_q <= 1'b1;
        end else if (ctrl_data_i[15:14] == 2'b10) begin
          if (32'(ridx) < NUM_REGS) regs_q[ridx] <= ctrl_data_i[7:0];
        end else begin
          code_q[1:0]  <= ctrl_data_i[15:14];
          addr_q[13:0] <= ctrl_data_i[13:0];
          pend_q       <= 1'b1;
        end
      end
    end
  end

  assign reg_val_o    = (32'(reg_sel_i) < NUM_REGS) ? regs_q[reg_sel_i] : '0;
  assign addr_o       = addr_q;
  assign acc_o        = decode_acc(code_q);
  assign pend_o       = pend_q;
  assign fetch_pend_o = fetch_pend_q;
endmodule

// File: rtl/vpc_fifo.sv
module vpc_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign dout_o  = mem_q[rp_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/vpc_mem.sv
module vpc_mem
  import vpc_pkg::*;
#(
  parameter int VRAM_AW = 10,
  parameter int VS_AW   = 6,
  localparam int CRAM_N = 64
) (
  input  logic        clk_i,
  input  logic        we_i,
  input  tgt_e        wtgt_i,
  input  logic [15:0] waddr_i,
  input  logic [15:0] wdata_i,
  input  tgt_e        rtgt_i,
  input  logic [15:0] raddr_i,
  output logic [15:0] rdata_o
);
  logic [15:0] vram_q  [2**VRAM_AW];
  logic [8:0]  cram_q  [CRAM_N];
  logic [15:0] vsram_q [2**VS_AW];
  logic        unused_addr;

  assign unused_addr = ^{waddr_i, raddr_i};

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      case (wtgt_i)
        TGT_VRAM:  vram_q[waddr_i[VRAM_AW:1]] <= wdata_i;
        TGT_CRAM:  cram_q[waddr_i[6:1]] <= {wdata_i[11:9], wdata_i[7:5], wdata_i[3:1]};
        TGT_VSRAM: vsram_q[waddr_i[VS_AW:1]] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    logic [8:0] c;
    c = cram_q[raddr_i[6:1]];
    case (rtgt_i)
      TGT_VRAM:  rdata_o = vram_q[raddr_i[VRAM_AW:1]];
      TGT_CRAM:  rdata_o = {4'h0, c[8:6], 1'b0, c[5:3], 1'b0, c[2:0], 1'b0};
      TGT_VSRAM: rdata_o = vsram_q[raddr_i[VS_AW:1]];
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/vpc_port.sv
module vpc_port
  import vpc_pkg::*;
#(
  parameter int VRAM_AW    = 10,
  parameter int VS_AW      = 6,
  parameter int FIFO_DEPTH = 4,
  parameter int NUM_REGS   = 24,
  parameter int STEP_REG   = 15,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_wr_i,
  input  logic        data_wr_i,
  input  logic        data_rd_i,
  input  logic        stat_rd_i,
  input  logic [15:0] bus_data_i,
  input  logic        slot_i,
  input  logic [7:0]  ext_stat_i,
  input  logic [4:0]  reg_sel_i,
  output logic        wait_o,
  output logic [15:0] rd_data_o,
  output logic [15:0] status_o,
  output logic [7:0]  reg_val_o
);
  acc_t         acc;
  logic [15:0]  addr_q, mem_rdata, rd_q;
  logic [7:0]   step;
  logic         pend, fetch_pend, fifo_empty, fifo_full;
  logic         wr_acc, rd_acc, fetch_go, pop;
  logic [CNT_W-1:0] fifo_cnt;
  logic [7:0]   fifo_lvl;
  wr_ent_t      push_ent, head;

  assign wr_acc   = data_wr_i && !fifo_full && !fetch_pend;
  assign rd_acc   = data_rd_i && !data_wr_i && !fetch_pend;
  assign fetch_go = fetch_pend && fifo_empty;
  assign pop      = slot_i && !fifo_empty;
  assign wait_o   = ((data_wr_i || data_rd_i) && fetch_pend) || (data_wr_i && fifo_full);
  assign fifo_lvl = 8'(fifo_cnt);

  vpc_cmd #(.NUM_REGS(NUM_REGS), .STEP_REG(STEP_REG)) u_cmd (
    .clk_i, .rst_ni, .ctrl_wr_i, .ctrl_data_i(bus_data_i), .stat_rd_i,
    .wr_acc_i(wr_acc), .rd_acc_i(rd_acc), .fetch_go_i(fetch_go),
    .reg_sel_i, .reg_val_o, .step_o(step), .addr_o(addr_q), .acc_o(acc),
    .pend_o(pend), .fetch_pend_o(fetch_pend)
  );

  // writes under a read command go nowhere
  assign push_ent = '{tgt: acc.rd ? TGT_NONE : acc.tgt, addr: addr_q, data: bus_data_i};

  vpc_fifo #(.W($bits(wr_ent_t)), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(wr_acc), .din_i(push_ent), .pop_i(pop),
    .dout_o(head), .empty_o(fifo_empty), .full_o(fifo_full), .count_o(fifo_cnt)
  );

  vpc_mem #(.VRAM_AW(VRAM_AW), .VS_AW(VS_AW)) u_mem (
    .clk_i, .we_i(pop), .wtgt_i(head.tgt), .waddr_i(head.addr), .wdata_i(head.data),
    .rtgt_i(acc.rd ? acc.tgt : TGT_NONE), .raddr_i(addr_q), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_q <= '0;
    else if (fetch_go) rd_q <= mem_rdata;
  end

  assign rd_data_o = rd_q;
  assign status_o  = {6'b001101, fifo_empty, fifo_full, ext_stat_i};
endmodule

// File: rtl/vpc_port_chk.sv
module vpc_port_chk #(
  parameter int DEPTH = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ctrl_wr_i,
  input logic        data_wr_i,
  input logic        stat_rd_i,
  input logic        slot_i,
  input logic [15:0] bus_data_i,
  input logic        wait_o,
  input logic [15:0] status_o,
  input logic [15:0] addr_i,
  input logic [7:0]  step_i,
  input logic        pend_i,
  input logic [7:0]  lvl_i
);
  logic unused_bits;
  assign unused_bits = ^bus_data_i[13:0];

  assert_flags_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[9] && status_o[8]));

  assert_empty_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[9] == (lvl_i == 8'd0));

  assert_level_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_i <= 8'(DEPTH));

  assert_stall_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && status_o[8]) |-> wait_o);

  assert_hold_no_slot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slot_i && !(data_wr_i && !wait_o)) |=> (lvl_i == $past(lvl_i)));

  assert_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && !wait_o && !ctrl_wr_i) |=> (addr_i == $past(addr_i) + {8'h00, $past(step_i)}));

  assert_pend_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_i && ctrl_wr_i && bus_data_i[15:14] != 2'b10) |=> pend_i);

  assert_pend_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !ctrl_wr_i && stat_rd_i) |=> !pend_i);
endmodule

bind vpc_port vpc_port_chk #(.DEPTH(4)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr_i), .data_wr_i(data_wr_i),
  .stat_rd_i(stat_rd_i), .slot_i(slot_i), .bus_data_i(bus_data_i), .wait_o(wait_o),
  .status_o(status_o), .addr_i(addr_q), .step_i(step), .pend_i(pend), .lvl_i(fifo_lvl)
);

// File: tb/vpc_port_test.sv
module vpc_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ctrl_wr = 0, data_wr = 0, data_rd = 0, stat_rd = 0, slot = 0;
  logic [15:0] bus = '0;
  logic [7:0]  ext_stat = '0;
  logic [4:0]  reg_sel = '0;
  logic        wait_w;
  logic [15:0] rd_data, status;
  logic [7:0]  reg_val;

  int n_checks = 0, n_fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vpc_port uut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .data_wr_i(data_wr),
    .data_rd_i(data_rd), .stat_rd_i(stat_rd), .bus_data_i(bus), .slot_i(slot),
    .ext_stat_i(ext_stat), .reg_sel_i(reg_sel), .wait_o(wait_w),
    .rd_data_o(rd_data), .status_o(status), .reg_val_o(reg_val)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk); #1;
  endtask

  task automatic ctrl(input logic [15:0] w);
    ctrl_wr = 1; bus = w; nxt(); ctrl_wr = 0;
  endtask

  task automatic cmd(input logic [15:0] w1, input logic [15:0] w2);
    ctrl(w1); ctrl(w2);
  endtask

  task automatic dwr(input logic [15:0] w);
    data_wr = 1; bus = w;
    @(negedge clk);
    while (wait_w) @(negedge clk);
    nxt(); data_wr = 0;
  endtask

  task automatic drd(input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    data_rd = 1;
    @(negedge clk);
    while (wait_w) @(negedge clk);
    nxt(); data_rd = 0;
  endtask

  task automatic slots(input int n);
    for (int i = 0; i < n; i++) begin
      slot = 1; nxt(); slot = 0;
    end
  endtask

  // scoreboard monitor: a read accepted at the coming edge returns the buffer
  always @(negedge clk) begin
    if (rst_n && data_rd && !data_wr && !wait_w) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected read", rd_data, 16'h0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 16'h0, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    nxt();
    chk(status == 16'h3600, "R1 status", status, 16'h3600);
    chk(wait_w == 1'b0, "R1 wait", {15'h0, wait_w}, 16'h0);
    chk(rd_data == 16'h0, "R1 rd_data", rd_data, 16'h0);

    ext_stat = 8'hA5; #1;
    chk(status == 16'h36A5, "R7 ext byte", status, 16'h36A5);
    ext_stat = 8'h00;

    ctrl(16'h8F02); ctrl(16'h872A); ctrl(16'h9811);
    reg_sel = 5'd15; #1 chk(reg_val == 8'h02, "R2 reg15", {8'h0, reg_val}, 16'h0002);
    reg_sel = 5'd7;  #1 chk(reg_val == 8'h2A, "R2 reg7", {8'h0, reg_val}, 16'h002A);
    reg_sel = 5'd24; #1 chk(reg_val == 8'h00, "R2 idx24 dropped", {8'h0, reg_val}, 16'h0000);

    cmd(16'h4010, 16'h0000);
    dwr(16'h1234); dwr(16'h5678);
    chk(status == 16'h3400, "R7 partial", status, 16'h3400);
    repeat (5) nxt();
    chk(status[9] == 1'b0, "R8 no slot no drain", status, 16'h3400);
    slots(2);
    chk(status == 16'h3600, "R8 drained", status, 16'h3600);
    cmd(16'h0010, 16'h0000);
    drd(16'h1234, "R11 prefetch");
    drd(16'h5678, "R5 step 2");

    cmd(16'h4100, 16'h0000);
    dwr(16'h1111); dwr(16'h2222); dwr(16'h3333); dwr(16'h4444);
    chk(status == 16'h3500, "R6 full flag", status, 16'h3500);
    fork
      dwr(16'h5555);
      begin
        @(negedge clk); @(negedge clk);
        chk(wait_w == 1'b1, "R6 stall", {15'h0, wait_w}, 16'h1);
        slots(1);
      end
    join
    chk(status == 16'h3500, "R6 refill", status, 16'h3500);
    slots(4);
    cmd(16'h0100, 16'h0000);
    drd(16'h1111, "R8 order 1"); drd(16'h2222, "R8 order 2");
    drd(16'h3333, "R8 order 3"); drd(16'h4444, "R8 order 4");
    drd(16'h5555, "R6 held write");

    cmd(16'h4020, 16'h0000);
    dwr(16'h9999);
    cmd(16'h0020, 16'h0000);
    fork
      drd(16'h9999, "R11 fetch after drain");
      begin
        @(negedge clk); @(negedge clk);
        chk(wait_w == 1'b1, "R11 wait on fetch", {15'h0, wait_w}, 16'h1);
        slots(1);
      end
    join

    cmd(16'hC002, 16'h0000);
    dwr(16'hFFFF); dwr(16'h0A52);
    slots(2);
    cmd(16'h0002, 16'h0020);
    drd(16'h0EEE, "R9 all ones");
    drd(16'h0A42, "R9 pattern");

    cmd(16'h4004, 16'h0000); dwr(16'h7777);
    cmd(16'h4004, 16'h0010); dwr(16'hABCD);
    slots(2);
    cmd(16'h0004, 16'h0010); drd(16'hABCD, "R3 scroll target");
    cmd(16'h0004, 16'h0000); drd(16'h7777, "R3 pattern target");

    cmd(16'hC010, 16'h0010); dwr(16'hDEAD); slots(1);
    cmd(16'h0010, 16'h0000); drd(16'h1234, "R4 bad code write");
    cmd(16'h0010, 16'h0030); drd(16'h0000, "R4 bad code read");

    ctrl(16'h8F04);
    cmd(16'h4200, 16'h0000); dwr(16'hA0A0); dwr(16'hB0B0);
    ctrl(16'h8F02);
    cmd(16'h4202, 16'h0000); dwr(16'hC0C0);
    slots(3);
    cmd(16'h0200, 16'h0000);
    drd(16'hA0A0, "R5 step4 a"); drd(16'hC0C0, "R5 step2 c"); drd(16'hB0B0, "R5 step4 b");

    cmd(16'h7FFE, 16'h0003); dwr(16'h1357); dwr(16'h2468); slots(2);
    cmd(16'h0000, 16'h0000); drd(16'h2468, "R5 wrap");

    ctrl(16'h4300);
    stat_rd = 1; nxt(); stat_rd = 0;
    ctrl(16'h8F06);
    reg_sel = 5'd15; #1 chk(reg_val == 8'h06, "R10 cleared by status", {8'h0, reg_val}, 16'h0006);
    ctrl(16'h4300); ctrl(16'h8F08);
    #1 chk(reg_val == 8'h06, "R10 second word not reg", {8'h0, reg_val}, 16'h0006);
    dwr(16'h4242); slots(1);
    cmd(16'h0300, 16'h0000); drd(16'h4242, "R10 second word cmd");

    repeat (4) nxt();
    chk(exp_q.size() == 0, "R11 reads pending", 16'(exp_q.size()), 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule